// File: doc/BRIEF.md
# Timer Match Output and Capture Unit

This block holds a 16-bit timer counter that advances by one on every clock in which its count enable is high. Four match channels watch the counter. When the counter arrives at a channel's match value, that channel applies a programmed 2-bit action to a persistent output status bit. The action can leave the bit alone, clear it, set it or invert it. Status bits for channels 0 to 2 drive output pins. Channel 3 has no pin, and its status can only be read back.

Two capture channels each sample an asynchronous input through a synchronizer. On the selected edge (rising, falling or both) a channel copies the counter into its capture register. Software uses a small word-addressed register port to load the counter, program match values, actions, per-channel PWM override flags and capture edge selects, and to read all of them back. A match channel whose PWM flag is set performs no action on its status bit.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset, the counter, all match values, all four status bits, all action fields, all PWM flags, all capture selects and both capture registers are 0, and `mat_o` is 0.
- R2: The counter (address 0) rises by one, wrapping from 0xFFFF to 0x0000, on each clock edge at which `cnt_en` is 1. It holds when `cnt_en` is 0. A write to address 0 loads the counter and takes precedence over counting.
- R3: The match control register at address 5 holds status bits in bits 3:0 and the action of channel i in bits 2i+5:2i+4. The action codes are 00 keep, 01 clear, 10 set and 11 invert. Match value i sits at address 1+i in bits 15:0. In the first cycle in which the counter equals match value i, the action fires, and the status bit reads back with its new value from the next clock edge on.
- R4: An action fires once each time equality begins. While the counter is stopped on the match value, the status bit is not changed again, so an invert action stays inverted.
- R5: When bit i of the PWM register at address 6 is 1, a match on channel i leaves status bit i unchanged.
- R6: A write to address 5 loads the status bits from `wr_data[3:0]`. It wins over a match action that fires in the same cycle.
- R7: `mat_o[i]` equals status bit i for channels 0 to 2. Status bit 3 reaches no pin and can only be read back.
- R8: Capture select c sits in bits 2c+1:2c of address 7. Bit 0 enables the rising edge and bit 1 enables the falling edge, so 11 selects both edges and 00 turns capture off. Suppose an input change is first sampled at clock edge k. On an enabled edge the capture register then takes the counter value held after edge k+1, and the register is loaded at edge k+2.
- R9: Capture register c reads at address 8+c, with the counter value in bits 15:0 and bits 31:16 reading 0. An edge that its select does not enable leaves the register unchanged.
- R10: Match values, the PWM flags and the capture selects read back as written, with unused bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| cap_in | input | 2 | Asynchronous capture inputs |
| mat_o | output | 3 | Match outputs of channels 0 to 2 |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, four match channels and two capture channels. With these values it can cover every channel, every action code, both starting values of every status bit, every capture select and both edge directions in a full sweep. Stopping the counter through `cnt_en` and loading it directly puts the wrap at 0xFFFF, a match while stopped, and an exact capture value within a few cycles. One capture with the counter running checks the two-cycle synchronizer latency as an arithmetic offset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MV0  = 4'd1;
  localparam logic [ADDR_W-1:0] A_EMR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_PWM  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CCTL = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAP0 = 4'd8;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_INV  = 2'b11
  } act_e;

  // new value of a status bit after a match with the given action
  function automatic logic apply_action(input logic cur, input logic [1:0] act);
    case (act_e'(act))
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      ACT_INV: return ~cur;
      default: return cur;
    endcase
  endfunction

  // whether a detected edge is enabled by a capture select
  function automatic logic edge_hit(input logic rise, input logic fall,
                                    input logic [1:0] sel);
    return (rise & sel[0]) | (fall & sel[1]);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_o <= '0;
    else if (ld) cnt_o <= ld_val;
    else if (en) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tmr_match_ch.sv
module tmr_match_ch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] mv,
  input  logic [1:0]       act,
  input  logic             cur,
  output logic             evt_o,
  output logic             nxt_o
);
  import tmr_pkg::*;
  logic eq_w;
  logic eq_q;

  assign eq_w = (cnt == mv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_w;
  end

  // fires only in the first cycle of equality
  assign evt_o = eq_w & ~eq_q;
  assign nxt_o = apply_action(cur, act);
endmodule

// File: rtl/tmr_cap_ch.sv
module tmr_cap_ch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_o,
  output logic             hit_o
);
  import tmr_pkg::*;
  logic s1_q, s2_q, s3_q;
  logic rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_w = s2_q & ~s3_q;
  assign fall_w = ~s2_q & s3_q;
  assign hit_o  = edge_hit(rise_w, fall_w, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_o <= '0;
    else if (hit_o) cap_o <= cnt;
  end
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 2,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_en,
  input  logic                  wr_en,
  input  logic [3:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [3:0]            rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [N_CAP-1:0]      cap_in,
  output logic [N_MATCH-2:0]    mat_o
);
  import tmr_pkg::*;
  localparam int ACT_LO = N_MATCH;
  localparam int ACT_HI = 3 * N_MATCH - 1;

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     mv_q  [N_MATCH];
  logic [2*N_MATCH-1:0] act_q;
  logic [N_MATCH-1:0]   status_q;
  logic [N_MATCH-1:0]   pwm_q;
  logic [2*N_CAP-1:0]   cctl_q;
  logic [CNT_W-1:0]     cap_w [N_CAP];
  logic [N_CAP-1:0]     hit_w;
  logic [N_MATCH-1:0]   evt_w, nxt_w, fire_w;
  logic                 wr_cnt, wr_emr, wr_pwm, wr_cctl;

  assign wr_cnt  = wr_en && (wr_addr == A_CNT);
  assign wr_emr  = wr_en && (wr_addr == A_EMR);
  assign wr_pwm  = wr_en && (wr_addr == A_PWM);
  assign wr_cctl = wr_en && (wr_addr == A_CCTL);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .ld(wr_cnt),
    .ld_val(wr_data[CNT_W-1:0]), .cnt_o(cnt_q)
  );

  for (genvar i = 0; i < N_MATCH; i++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mv_q[i] <= '0;
      else if (wr_en && (wr_addr == 4'(A_MV0 + i))) mv_q[i] <= wr_data[CNT_W-1:0];
    end
    tmr_match_ch #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .mv(mv_q[i]),
      .act(act_q[2*i+1:2*i]), .cur(status_q[i]),
      .evt_o(evt_w[i]), .nxt_o(nxt_w[i])
    );
  end

  assign fire_w = evt_w & ~pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      act_q    <= '0;
    end else if (wr_emr) begin
      status_q <= wr_data[N_MATCH-1:0];
      act_q    <= wr_data[ACT_HI:ACT_LO];
    end else begin
      for (int i = 0; i < N_MATCH; i++)
        if (fire_w[i]) status_q[i] <= nxt_w[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= '0;
      cctl_q <= '0;
    end else begin
      if (wr_pwm)  pwm_q  <= wr_data[N_MATCH-1:0];
      if (wr_cctl) cctl_q <= wr_data[2*N_CAP-1:0];
    end
  end

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    tmr_cap_ch #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[c]), .sel(cctl_q[2*c+1:2*c]),
      .cnt(cnt_q), .cap_o(cap_w[c]), .hit_o(hit_w[c])
    );
  end

  assign mat_o = status_q[N_MATCH-2:0];

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CNT)  rd_data[CNT_W-1:0] = cnt_q;
    if (rd_addr == A_EMR)  rd_data[ACT_HI:0]  = {act_q, status_q};
    if (rd_addr == A_PWM)  rd_data[N_MATCH-1:0] = pwm_q;
    if (rd_addr == A_CCTL) rd_data[2*N_CAP-1:0] = cctl_q;
    for (int i = 0; i < N_MATCH; i++)
      if (rd_addr == 4'(A_MV0 + i)) rd_data[CNT_W-1:0] = mv_q[i];
    for (int c = 0; c < N_CAP; c++)
      if (rd_addr == 4'(A_CAP0 + c)) rd_data[CNT_W-1:0] = cap_w[c];
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_en,
  input logic               wr_en,
  input logic [3:0]         wr_addr,
  input logic [31:0]        wr_data,
  input logic [3:0]         rd_addr,
  input logic [31:0]        rd_data,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [N_MATCH-1:0] status_q,
  input logic [N_MATCH-1:0] evt_w,
  input logic [N_MATCH-1:0] pwm_q
);
  import tmr_pkg::*;
  logic wr_emr_c, wr_cnt_c;
  assign wr_emr_c = wr_en && (wr_addr == A_EMR);
  assign wr_cnt_c = wr_en && (wr_addr == A_CNT);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !wr_cnt_c) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en) |=> $stable(cnt_q));
  // R4
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en) |=> (evt_w == '0));
  // R3
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((evt_w & ~pwm_q) == '0) && !wr_emr_c) |=> $stable(status_q));
  // R5
  pwm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&pwm_q) && !wr_emr_c) |=> $stable(status_q));
  // R6
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_emr_c |=> (status_q == $past(wr_data[N_MATCH-1:0])));
  // R9
  cap_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= A_CAP0) |-> (rd_data[31:16] == 16'h0));
endmodule

bind tmr_match_capture tmr_checker #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_q(cnt_q),
  .status_q(status_q), .evt_w(evt_w), .pwm_q(pwm_q)
);

// File: tb/tmr_match_capture_bench.sv
module tmr_match_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  cap_in = '0;
  logic [2:0]  mat_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_match_capture u_tmr_match_capture (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in),
    .mat_o(mat_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic model_act(input logic b, input int a);
    if (a == 1) return 1'b0;
    if (a == 2) return 1'b1;
    if (a == 3) return !b;
    return b;
  endfunction

  task automatic pulse_count();
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_emr;
    logic [15:0] exp_cap [2];
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset mat_o", {29'h0, mat_o}, 32'h0);

    // R10 readback
    wr(4'd2, 32'hFFFF_ABCD); rd(4'd2, v); chk("R10 match value", v, 32'h0000_ABCD);
    wr(4'd6, 32'hFFFF_FFF5); rd(4'd6, v); chk("R10 pwm flags", v, 32'h5);
    wr(4'd7, 32'hFFFF_FFF9); rd(4'd7, v); chk("R10 capture select", v, 32'h9);
    wr(4'd6, 32'h0); wr(4'd7, 32'h0);

    // R2 wrap and hold
    wr(4'd0, 32'h0000_FFFE);
    @(negedge clk); cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    rd(4'd0, v); chk("R2 wrap count", v, 32'h1);
    repeat (4) @(negedge clk);
    rd(4'd0, v); chk("R2 hold count", v, 32'h1);

    // R3 R4 R7 sweep: channel x action x starting bit
    for (int ch = 0; ch < 4; ch++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 2; b++) begin
          wr(4'd0, 32'h1233);
          wr(4'(1 + ch), 32'h1234);
          wr(4'd5, (32'(a) << (4 + 2*ch)) | (32'(b) << ch));
          pulse_count();
          repeat (3) @(negedge clk);
          exp_emr = (32'(a) << (4 + 2*ch)) | (32'(model_act(b[0], a)) << ch);
          rd(4'd5, v);
          chk("R3 R4 match action status", v, exp_emr);
          chk("R7 match pins", {29'h0, mat_o}, exp_emr & 32'h7);
        end
      end
    end

    // R5 pwm override blocks an invert
    for (int ch = 0; ch < 4; ch++) begin
      wr(4'd6, 32'(1) << ch);
      wr(4'd0, 32'h1233);
      wr(4'(1 + ch), 32'h1234);
      wr(4'd5, 32'(3) << (4 + 2*ch));
      pulse_count();
      repeat (3) @(negedge clk);
      rd(4'd5, v);
      chk("R5 pwm override", v, 32'(3) << (4 + 2*ch));
    end
    wr(4'd6, 32'h0);

    // R6 software write in the match cycle wins
    wr(4'd0, 32'h1233);
    wr(4'd1, 32'h1234);
    wr(4'd5, 32'h30);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'h34;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rd(4'd5, v); chk("R6 write beats match", v, 32'h34);
    wr(4'd5, 32'h0);

    // R8 R9 capture sweep with stopped counter
    exp_cap[0] = '0; exp_cap[1] = '0;
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 4; s++) begin
        wr(4'd7, 32'(s) << (2*c));
        for (int e = 0; e < 2; e++) begin
          logic rising;
          wr(4'd0, 32'(16'h1000 * (c + 1) + 16'(s * 4 + e + 1)));
          rising = !cap_in[c];
          @(negedge clk); cap_in[c] = !cap_in[c];
          repeat (5) @(negedge clk);
          if ((rising && s[0]) || (!rising && s[1]))
            exp_cap[c] = 16'h1000 * 16'(c + 1) + 16'(s * 4 + e + 1);
          rd(4'(8 + c), v); chk("R8 R9 capture value", v, {16'h0, exp_cap[c]});
          rd(4'(9 - c), v); chk("R9 other capture untouched", v, {16'h0, exp_cap[1-c]});
        end
      end
    end

    // R8 latency with counter running
    wr(4'd7, 32'h1);
    @(negedge clk); cnt_en = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd0, v); c0 = v[15:0];
    cap_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    cnt_en = 1'b0;
    rd(4'd8, v); chk("R8 running capture offset", v, {16'h0, 16'(c0 + 16'd2)});

    finish_run();
  end
endmodule